// File: doc/BRIEF.md
# Receive Polarity Detector and Corrector

This block decides whether the receive pair of a twisted-pair port has been wired with its two conductors swapped, and if so it inverts the receive data bit. It works from events that have already been qualified upstream: a link pulse seen with a known polarity, an end-of-packet strobe that says whether the end delimiter was valid and which polarity it had, and a link-fail indication from the link monitor. Squelch, pulse-width qualification and delimiter decoding happen elsewhere.

After reset, or while link fail is asserted, the block sits in a link-down state. While link is down it counts link pulses of the same polarity that arrive in a row. When the count reaches the configured run length, link comes up and that polarity becomes the first polarity setting. Once link is up, the end delimiters of packets take over. The first valid delimiter sets the polarity. A later valid delimiter that disagrees replaces the setting and keeps the detector armed. Two valid delimiters in a row that agree lock the setting until the next link fail or reset. A strap input held low turns correction off. All control and status pins are plain levels or one-cycle strobes. No data stream in the block has back-pressure: the receive bit passes through combinationally, with no valid/ready handshake.

Top module: `rxpol_corrector`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), invert_o is 0, pol_ok_n_o is 0, pol_chg_o is 0, link is down, and no delimiter has been seen.
- R2: While link is down, a link pulse (lp_valid=1; lp_neg=1 means negative, 0 means positive) extends the run if it matches the polarity of the previous pulse in the run, and otherwise restarts the run at one. The pulse that completes a run of PULSES_TO_PASS (default 5) brings link up and sets invert_o to that lp_neg value, visible one cycle later.
- R3: While link is up, link pulses of either polarity never change invert_o.
- R4: With link up, the first valid delimiter after reset or link fail (eop_valid=1, eop_dlm_ok=1) sets invert_o to eop_dlm_neg (1 = reversed) one cycle later, whatever the current setting.
- R5: A later valid delimiter whose polarity differs from the previous valid delimiter becomes the new setting, and the detector stays armed.
- R6: Two consecutive valid delimiters of the same polarity lock the setting. Valid delimiters after that do not change invert_o until link fail or reset.
- R7: An end-of-packet strobe with eop_dlm_ok=0 changes neither invert_o nor the count of agreeing delimiters.
- R8: link_fail_i high takes link down and re-arms the detector without changing invert_o. The next run of pulses, and then the next first delimiter, each set the polarity again.
- R9: End-of-packet strobes that arrive while link is down are ignored.
- R10: corr_strap_n_i low forces invert_o to 0 and pol_ok_n_o low. Raising it again shows the internal decision.
- R11: pol_ok_n_o equals invert_o (low = normal polarity, high = reversal active), and rx_bit_o equals rx_bit_i XOR invert_o.
- R12: invert_o changes only in the cycle after a link pulse or end-of-packet strobe. pol_chg_o pulses high for exactly one cycle, in the same cycle the internal decision takes its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| corr_strap_n_i | input | 1 | Strap; low disables correction |
| link_fail_i | input | 1 | Link fail from the link monitor, level |
| lp_valid_i | input | 1 | Qualified link pulse strobe |
| lp_neg_i | input | 1 | Link pulse polarity, 1 = negative |
| eop_valid_i | input | 1 | End-of-packet strobe |
| eop_dlm_ok_i | input | 1 | End delimiter was valid |
| eop_dlm_neg_i | input | 1 | End delimiter polarity, 1 = reversed |
| rx_bit_i | input | 1 | Receive data bit before correction |
| rx_bit_o | output | 1 | Receive data bit after correction |
| invert_o | output | 1 | Invert control applied to receive data |
| pol_ok_n_o | output | 1 | Polarity indicator, low = normal |
| pol_chg_o | output | 1 | One-cycle strobe on each decision change |

## Verification
The assertions assume that the link pulse and end-of-packet strobes are each one cycle wide. They also assume that an end-of-packet strobe arriving in the same cycle as link_fail_i counts for nothing. Under these assumptions, a locked decision or a quiet input must leave the invert bit untouched. The stimulus drives every strobe for exactly one clock, on the falling edge. It never overlaps link pulses with end-of-packet strobes. It raises link fail only between events, so every expected value follows from the event order alone.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;
  typedef enum logic [1:0] {
    DLM_NONE = 2'd0,
    DLM_ONE  = 2'd1,
    DLM_LOCK = 2'd2
  } dlm_state_e;
endpackage

// File: rtl/rxpol_link_track.sv
module rxpol_link_track #(
  parameter int PULSES_TO_PASS = 5,
  localparam int CNT_W = $clog2(PULSES_TO_PASS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_fail,
  input  logic lp_valid,
  input  logic lp_neg,
  output logic link_up,
  output logic pass_evt,
  output logic pass_neg
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             last_neg_q;
  logic             up_q;
  logic             hit, same;

  assign hit      = lp_valid && !up_q && !link_fail;
  assign same     = (cnt_q != '0) && (lp_neg == last_neg_q);
  assign cnt_nxt  = same ? cnt_q + CNT_W'(1) : CNT_W'(1);
  assign pass_evt = hit && (cnt_nxt == CNT_W'(PULSES_TO_PASS));
  assign pass_neg = lp_neg;
  assign link_up  = up_q;

  always_ff @(posedge clk) begin
    if (!rst_n || link_fail) begin
      up_q       <= 1'b0;
      cnt_q      <= '0;
      last_neg_q <= 1'b0;
    end else if (hit) begin
      last_neg_q <= lp_neg;
      if (pass_evt) begin
        up_q  <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  // R8: link fail always takes link down
  assert_fail_drops_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |=> !up_q);
  // R2: link comes up only on a link pulse
  assert_pass_needs_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> $past(lp_valid));
endmodule

// File: rtl/rxpol_dlm_arbiter.sv
module rxpol_dlm_arbiter
  import rxpol_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic link_fail,
  input  logic link_up,
  input  logic eop_valid,
  input  logic eop_ok,
  input  logic eop_neg,
  output logic set_evt,
  output logic set_neg,
  output logic locked
);
  dlm_state_e st_q, st_d;
  logic       last_q, last_d;
  logic       take;

  assign take    = eop_valid && eop_ok && link_up && !link_fail;
  assign set_neg = eop_neg;
  assign locked  = (st_q == DLM_LOCK);

  always_comb begin
    st_d    = st_q;
    last_d  = last_q;
    set_evt = 1'b0;
    if (take) begin
      unique case (st_q)
        DLM_NONE: begin
          set_evt = 1'b1;
          last_d  = eop_neg;
          st_d    = DLM_ONE;
        end
        DLM_ONE: begin
          if (eop_neg == last_q) begin
            st_d = DLM_LOCK;
          end else begin
            set_evt = 1'b1;
            last_d  = eop_neg;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || link_fail) begin
      st_q   <= DLM_NONE;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      last_q <= last_d;
    end
  end

  // R7: an invalid delimiter leaves the agreement state alone
  assert_invalid_dlm_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_valid && !eop_ok && !link_fail) |=> ($stable(st_q) && $stable(last_q)));
  // R6: lock persists until link fail
  assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !link_fail) |=> locked);
  // R9: no delimiter progress while link down
  assert_down_ignores_dlm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && !link_fail && st_q == DLM_NONE) |=> (st_q == DLM_NONE));
endmodule

// File: rtl/rxpol_corrector.sv
module rxpol_corrector #(
  parameter int PULSES_TO_PASS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic corr_strap_n_i,
  input  logic link_fail_i,
  input  logic lp_valid_i,
  input  logic lp_neg_i,
  input  logic eop_valid_i,
  input  logic eop_dlm_ok_i,
  input  logic eop_dlm_neg_i,
  input  logic rx_bit_i,
  output logic rx_bit_o,
  output logic invert_o,
  output logic pol_ok_n_o,
  output logic pol_chg_o
);
  logic link_up, pass_evt, pass_neg;
  logic set_evt, set_neg, locked;
  logic inv_q, inv_d, chg_q;

  rxpol_link_track #(.PULSES_TO_PASS(PULSES_TO_PASS)) link_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_fail(link_fail_i),
    .lp_valid (lp_valid_i),
    .lp_neg   (lp_neg_i),
    .link_up  (link_up),
    .pass_evt (pass_evt),
    .pass_neg (pass_neg)
  );

  rxpol_dlm_arbiter dlm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_fail(link_fail_i),
    .link_up  (link_up),
    .eop_valid(eop_valid_i),
    .eop_ok   (eop_dlm_ok_i),
    .eop_neg  (eop_dlm_neg_i),
    .set_evt  (set_evt),
    .set_neg  (set_neg),
    .locked   (locked)
  );

  always_comb begin
    inv_d = inv_q;
    if (link_fail_i) inv_d = inv_q;
    else if (set_evt) inv_d = set_neg;
    else if (pass_evt) inv_d = pass_neg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      inv_q <= inv_d;
      chg_q <= (inv_d != inv_q);
    end
  end

  assign invert_o   = inv_q && corr_strap_n_i;
  assign pol_ok_n_o = invert_o;
  assign rx_bit_o   = rx_bit_i ^ invert_o;
  assign pol_chg_o  = chg_q;

  // R12: no event, no change of decision
  assert_quiet_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_valid_i && !eop_valid_i) |=> $stable(inv_q));
  // R6: a locked decision is frozen
  assert_locked_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !link_fail_i) |=> $stable(inv_q));
  // R3: link pulses while link up never move the decision
  assert_up_pulse_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && lp_valid_i && !eop_valid_i) |=> $stable(inv_q));
endmodule

// File: tb/rxpol_corrector_tb_top.sv
module rxpol_corrector_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_n = 1'b1, lfail = 1'b0, lpv = 1'b0, lpn = 1'b0;
  logic eopv = 1'b0, eopok = 1'b0, eopn = 1'b0, rxi = 1'b0;
  logic rxo, inv, polokn, chg;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rxpol_corrector #(.PULSES_TO_PASS(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .corr_strap_n_i(strap_n), .link_fail_i(lfail),
    .lp_valid_i(lpv), .lp_neg_i(lpn), .eop_valid_i(eopv), .eop_dlm_ok_i(eopok),
    .eop_dlm_neg_i(eopn), .rx_bit_i(rxi), .rx_bit_o(rxo), .invert_o(inv),
    .pol_ok_n_o(polokn), .pol_chg_o(chg)
  );

  task automatic check(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic lp(logic neg);
    @(negedge clk) begin lpv = 1'b1; lpn = neg; end
    @(negedge clk) lpv = 1'b0;
  endtask

  task automatic eop(logic ok, logic neg);
    @(negedge clk) begin eopv = 1'b1; eopok = ok; eopn = neg; end
    @(negedge clk) eopv = 1'b0;
  endtask

  task automatic link_fail_pulse();
    @(negedge clk) lfail = 1'b1;
    @(negedge clk) lfail = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 invert", inv, 1'b0);
    check("R1 pol_ok_n", polokn, 1'b0);
    check("R1 chg", chg, 1'b0);
  endtask

  task automatic t_pulse_run();
    do_reset();
    for (int i = 0; i < 4; i++) lp(1'b1);
    check("R2 four pulses not enough", inv, 1'b0);
    lp(1'b0);
    for (int i = 0; i < 4; i++) lp(1'b1);
    check("R2 run restarted by opposite pulse", inv, 1'b0);
    lp(1'b1);
    check("R2 fifth matching pulse sets invert", inv, 1'b1);
    check("R12 chg strobe", chg, 1'b1);
    check("R11 pol_ok_n high", polokn, 1'b1);
    rxi = 1'b0; #0;
    check("R11 rx inverted", rxo, 1'b1);
    @(negedge clk);
    check("R12 chg one cycle", chg, 1'b0);
  endtask

  task automatic t_up_pulses();
    for (int i = 0; i < 6; i++) lp(1'b0);
    check("R3 pulses after link up ignored", inv, 1'b1);
    check("R12 no chg", chg, 1'b0);
  endtask

  task automatic t_delims();
    eop(1'b1, 1'b0);
    check("R4 first delimiter sets", inv, 1'b0);
    eop(1'b1, 1'b1);
    check("R5 disagreeing delimiter adopted", inv, 1'b1);
    eop(1'b1, 1'b0);
    check("R5 still armed", inv, 1'b0);
    eop(1'b1, 1'b0);
    check("R6 agree locks", inv, 1'b0);
    eop(1'b1, 1'b1);
    check("R6 locked ignores delimiter", inv, 1'b0);
    repeat (3) @(negedge clk);
    check("R12 quiet stable", inv, 1'b0);
  endtask

  task automatic t_refail_invalid();
    link_fail_pulse();
    check("R8 link fail keeps invert", inv, 1'b0);
    eop(1'b1, 1'b1);
    check("R9 delimiter while down ignored", inv, 1'b0);
    for (int i = 0; i < 5; i++) lp(1'b1);
    check("R8 pulses set polarity after fail", inv, 1'b1);
    eop(1'b1, 1'b0);
    check("R8 first delimiter after fail", inv, 1'b0);
    eop(1'b0, 1'b1);
    check("R7 invalid delimiter no change", inv, 1'b0);
    eop(1'b1, 1'b0);
    eop(1'b1, 1'b1);
    check("R7 invalid kept agreement count", inv, 1'b0);
  endtask

  task automatic t_strap();
    link_fail_pulse();
    for (int i = 0; i < 5; i++) lp(1'b1);
    check("R10 decision reversed", inv, 1'b1);
    @(negedge clk) strap_n = 1'b0;
    rxi = 1'b1; #0;
    check("R10 strap forces invert 0", inv, 1'b0);
    check("R10 strap pol_ok_n low", polokn, 1'b0);
    check("R10 strap rx passthrough", rxo, 1'b1);
    @(negedge clk) strap_n = 1'b1;
    #0;
    check("R10 release restores", inv, 1'b1);
  endtask

  task automatic t_reset_rearm();
    eop(1'b1, 1'b1);
    eop(1'b1, 1'b1);
    do_reset();
    check("R1 reset clears lock", inv, 1'b0);
    eop(1'b1, 1'b1);
    check("R9 down after reset", inv, 1'b0);
  endtask

  initial begin
    t_reset();
    t_pulse_run();
    t_up_pulses();
    t_delims();
    t_refail_invalid();
    t_strap();
    t_reset_rearm();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule